// File: doc/BRIEF.md
# Software Flow-Control Character Inserter

This block decides when a UART transmitter must send software flow-control characters to the far end. It watches the fill level of the local receive FIFO. When the level climbs above a programmable halt threshold, it produces a two-character stop burst. When the level drains back to a programmable resume threshold, it produces a two-character go burst. A 2-bit mode picks which of the two programmable stop characters and two programmable go characters make up a burst.

The block offers each character to the transmit serializer on a valid/ready handshake, and holds it there until the serializer accepts it. The serializer gives a raised `ctl_valid` priority over FIFO data at its next character boundary. A character already on the line is never cut short.

The block records whether a stop burst is outstanding. If software flow control is switched off while a stop burst is outstanding, the block sends the go burst by itself so that the far end is not left halted. Characters are trimmed to the configured word length, exactly as ordinary data bytes are.

Top module: `xon_xoff_inserter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `ctl_valid` is 0 and no stop burst is recorded as outstanding.
- R2: A stop burst begins when all of the following hold: `sw_fc_en` is 1, `tx_mode` is not 00, no stop burst is outstanding, and `rx_level` is strictly greater than `halt_thr`×4. `ctl_valid` rises one clock after that condition is seen. A level equal to `halt_thr`×4 starts nothing.
- R3: The mode selects the characters of a burst as follows. With mode 10, both characters are pair-one characters (`xoff1`,`xoff1` or `xon1`,`xon1`). With mode 01, both are pair-two characters. With mode 11, the pair-one character goes first and the pair-two character second.
- R4: While a stop burst is outstanding and flow control is active, a go burst begins once `rx_level` is less than or equal to `resume_thr`×4. A level of `resume_thr`×4+1 starts nothing.
- R5: A second stop burst never starts while one is outstanding, even if the level stays above the halt threshold. A go burst never starts when no stop burst is outstanding.
- R6: With `sw_fc_en` at 0 or `tx_mode` at 00, and no stop burst outstanding, no burst starts at any fill level.
- R7: If flow control becomes inactive while a stop burst is outstanding, a go burst starts by itself, whatever the fill level.
- R8: Each character stays on `ctl_char`, with `ctl_valid` high, until a cycle in which `ctl_ready` is 1. The burst then moves on one character per accepted handshake, and `ctl_valid` drops after the second character is accepted.
- R9: `word_len` selects the character width: 00 is 5 bits, 01 is 6, 10 is 7 and 11 is 8. Bits above the selected width read as 0 on `ctl_char`.
- R10: The characters of a go burst follow the mode captured when the stop burst began. A later change of `tx_mode` does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_fc_en | input | 1 | Software flow control enable |
| tx_mode | input | 2 | Character selection mode (00 none, 10 pair one, 01 pair two, 11 both in order) |
| rx_level | input | LVL_W | Receive FIFO fill level |
| halt_thr | input | THR_W | Halt threshold in units of 4 entries |
| resume_thr | input | THR_W | Resume threshold in units of 4 entries |
| xon1 | input | 8 | First go character |
| xon2 | input | 8 | Second go character |
| xoff1 | input | 8 | First stop character |
| xoff2 | input | 8 | Second stop character |
| word_len | input | 2 | Word length code (00=5 … 11=8 bits) |
| ctl_ready | input | 1 | Serializer accepts the offered character |
| ctl_valid | output | 1 | A control character is offered |
| ctl_char | output | 8 | Offered control character, trimmed to the word length |

## Verification
The hardest case to reach from the ports is the automatic go burst. To get there, a complete stop burst must first be driven out and accepted. Only then is flow control switched off, and at the same moment the mode is changed, so that the bench can see that the go characters follow the mode that was captured earlier. A shared table runs a full stop-then-go cycle for every mode and word-length pairing. Directed sequences then hold the fill level exactly on each threshold boundary and keep it above the halt threshold after a burst, to show that no second burst follows.

// File: rtl/flowctl_pkg.sv
// Package: shared types for the software flow-control character inserter.
// Assumes characters are 8 bits wide and word lengths range from 5 to 8 bits.
package flowctl_pkg;

    localparam int CHAR_W = 8;

    typedef enum logic [1:0] {
        BURST_IDLE   = 2'd0,
        BURST_FIRST  = 2'd1,
        BURST_SECOND = 2'd2
    } burst_state_t;

    typedef enum logic {
        KIND_GO   = 1'b0,
        KIND_STOP = 1'b1
    } ctl_kind_t;

    localparam logic [1:0] MODE_NONE = 2'b00;
    localparam logic [1:0] MODE_PAIR2 = 2'b01;
    localparam logic [1:0] MODE_PAIR1 = 2'b10;
    localparam logic [1:0] MODE_BOTH = 2'b11;

    // Mask keeping the low 5..8 bits: code 00 -> 5 bits, 11 -> 8 bits.
    function automatic logic [CHAR_W-1:0] word_mask(input logic [1:0] code);
        return {CHAR_W{1'b1}} >> (2'd3 - code);
    endfunction

endpackage

// File: rtl/fill_watch.sv
// fill_watch: compares the receive FIFO level against the halt and resume
// thresholds. Each threshold is given in units of 2**SCALE_LOG2 entries.
// Assumes the level and thresholds are stable, synchronous inputs.
module fill_watch #(
    parameter int LVL_W      = 7,
    parameter int THR_W      = 4,
    parameter int SCALE_LOG2 = 2
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [THR_W-1:0] halt_thr,
    input  logic [THR_W-1:0] resume_thr,
    output logic             over_halt,
    output logic             at_resume
);
    localparam int THR_SCALED_W = THR_W + SCALE_LOG2;
    localparam int CMP_W = (LVL_W > THR_SCALED_W) ? LVL_W : THR_SCALED_W;

    logic [CMP_W-1:0] level_x;
    logic [CMP_W-1:0] halt_x;
    logic [CMP_W-1:0] resume_x;

    // Widen all operands to a common width and scale the thresholds.
    always_comb begin
        level_x  = CMP_W'(rx_level);
        halt_x   = CMP_W'({halt_thr, {SCALE_LOG2{1'b0}}});
        resume_x = CMP_W'({resume_thr, {SCALE_LOG2{1'b0}}});
    end

    // Strictly above halt; at or below resume.
    always_comb begin
        over_halt = level_x > halt_x;
        at_resume = level_x <= resume_x;
    end
endmodule

// File: rtl/burst_seq.sv
// burst_seq: decides when a stop or go burst starts, and steps a burst
// through its two characters on the serializer handshake. It keeps the
// stop-outstanding flag and the mode captured at the start of the stop burst.
// Assumes flow_active already combines the enable bit and a non-zero mode.
module burst_seq
    import flowctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flow_active,
    input  logic [1:0] tx_mode,
    input  logic       over_halt,
    input  logic       at_resume,
    input  logic       ctl_ready,
    output logic       ctl_valid,
    output logic       second_char,
    output ctl_kind_t  kind_q,
    output logic [1:0] mode_q,
    output logic       stop_sent
);
    burst_state_t state_q;
    logic         start_stop;
    logic         start_go;

    // Burst start conditions; only evaluated while no burst is in flight.
    always_comb begin
        start_stop = (state_q == BURST_IDLE) && flow_active && !stop_sent && over_halt;
        start_go   = (state_q == BURST_IDLE) && stop_sent && (!flow_active || at_resume);
    end

    // Burst state, character kind, captured mode and outstanding flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= BURST_IDLE;
            kind_q    <= KIND_GO;
            mode_q    <= MODE_NONE;
            stop_sent <= 1'b0;
        end else begin
            case (state_q)
                BURST_IDLE: begin
                    if (start_stop) begin
                        state_q   <= BURST_FIRST;
                        kind_q    <= KIND_STOP;
                        mode_q    <= tx_mode;
                        stop_sent <= 1'b1;
                    end else if (start_go) begin
                        state_q   <= BURST_FIRST;
                        kind_q    <= KIND_GO;
                        stop_sent <= 1'b0;
                    end
                end
                BURST_FIRST: begin
                    if (ctl_ready) state_q <= BURST_SECOND;
                end
                BURST_SECOND: begin
                    if (ctl_ready) state_q <= BURST_IDLE;
                end
                default: state_q <= BURST_IDLE;
            endcase
        end
    end

    // Decoded handshake outputs.
    always_comb begin
        ctl_valid   = (state_q != BURST_IDLE);
        second_char = (state_q == BURST_SECOND);
    end

    // R8
    burst_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (second_char && ctl_ready) |=> !ctl_valid);

    // R2
    stop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_sent) |-> ($past(over_halt) && $past(flow_active)));

    // R5
    go_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_sent) |-> (ctl_valid && kind_q == KIND_GO));

    // R6
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_valid && !flow_active && !stop_sent) |=> !ctl_valid);
endmodule

// File: rtl/char_pick.sv
// char_pick: chooses the character for the current burst position, based
// on the burst kind and the captured mode, then trims it to the word length.
// Assumes the mode is non-zero while a burst is in flight.
module char_pick
    import flowctl_pkg::*;
(
    input  ctl_kind_t         kind_q,
    input  logic [1:0]        mode_q,
    input  logic              second_char,
    input  logic              ctl_valid,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic [1:0]        word_len,
    output logic [CHAR_W-1:0] ctl_char
);
    logic              use_pair2;
    logic [CHAR_W-1:0] raw_char;
    logic [CHAR_W-1:0] keep_mask;

    // Pick pair one or pair two for this burst position.
    always_comb begin
        case (mode_q)
            MODE_PAIR2: use_pair2 = 1'b1;
            MODE_BOTH:  use_pair2 = second_char;
            default:    use_pair2 = 1'b0;
        endcase
    end

    // Select the raw character and trim it to the word width.
    always_comb begin
        if (kind_q == KIND_STOP) raw_char = use_pair2 ? xoff2 : xoff1;
        else                     raw_char = use_pair2 ? xon2 : xon1;
        keep_mask = word_mask(word_len);
        ctl_char  = raw_char & keep_mask;
    end

    // R9
    width_trim_chk: assert property (@(posedge ctl_valid)
        (word_len == 2'b00) |-> (ctl_char[CHAR_W-1:5] == '0));
endmodule

// File: rtl/xon_xoff_inserter.sv
// xon_xoff_inserter: top of the software flow-control character inserter.
// Raises a stop burst when the receive FIFO fills past the halt threshold and
// a go burst when it drains to the resume threshold or when flow control is
// switched off. The serializer gives ctl_valid priority over FIFO data at its
// next character boundary. Assumes hardware flow control is never enabled
// at the same time.
module xon_xoff_inserter
    import flowctl_pkg::*;
#(
    parameter int LVL_W      = 7,
    parameter int THR_W      = 4,
    parameter int SCALE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_fc_en,
    input  logic [1:0]        tx_mode,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [THR_W-1:0]  halt_thr,
    input  logic [THR_W-1:0]  resume_thr,
    input  logic [CHAR_W-1:0] xon1,
    input  logic [CHAR_W-1:0] xon2,
    input  logic [CHAR_W-1:0] xoff1,
    input  logic [CHAR_W-1:0] xoff2,
    input  logic [1:0]        word_len,
    input  logic              ctl_ready,
    output logic              ctl_valid,
    output logic [CHAR_W-1:0] ctl_char
);
    logic       over_halt;
    logic       at_resume;
    logic       flow_active;
    logic       second_char;
    ctl_kind_t  kind_q;
    logic [1:0] mode_q;
    logic       stop_sent;

    // Flow control counts as active only with the enable set and a mode chosen.
    always_comb flow_active = sw_fc_en && (tx_mode != MODE_NONE);

    fill_watch #(
        .LVL_W(LVL_W), .THR_W(THR_W), .SCALE_LOG2(SCALE_LOG2)
    ) u_watch (
        .rx_level(rx_level), .halt_thr(halt_thr), .resume_thr(resume_thr),
        .over_halt(over_halt), .at_resume(at_resume)
    );

    burst_seq u_seq (
        .clk(clk), .rst_n(rst_n), .flow_active(flow_active), .tx_mode(tx_mode),
        .over_halt(over_halt), .at_resume(at_resume), .ctl_ready(ctl_ready),
        .ctl_valid(ctl_valid), .second_char(second_char), .kind_q(kind_q),
        .mode_q(mode_q), .stop_sent(stop_sent)
    );

    char_pick u_pick (
        .kind_q(kind_q), .mode_q(mode_q), .second_char(second_char),
        .ctl_valid(ctl_valid), .xon1(xon1), .xon2(xon2), .xoff1(xoff1),
        .xoff2(xoff2), .word_len(word_len), .ctl_char(ctl_char)
    );

    // R8
    hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_char)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !ctl_valid);
endmodule

// File: tb/xon_xoff_inserter_test.sv
`timescale 1ns/1ps
module xon_xoff_inserter_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_fc_en = 1'b0;
    logic [1:0] tx_mode = 2'b00;
    logic [6:0] rx_level = '0;
    logic [3:0] halt_thr = 4'd4;
    logic [3:0] resume_thr = 4'd2;
    logic [7:0] xon1 = 8'hF1, xon2 = 8'hE2, xoff1 = 8'hD3, xoff2 = 8'hC4;
    logic [1:0] word_len = 2'b11;
    logic       ctl_ready = 1'b0;
    logic       ctl_valid;
    logic [7:0] ctl_char;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    xon_xoff_inserter uut (
        .clk(clk), .rst_n(rst_n), .sw_fc_en(sw_fc_en), .tx_mode(tx_mode),
        .rx_level(rx_level), .halt_thr(halt_thr), .resume_thr(resume_thr),
        .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
        .word_len(word_len), .ctl_ready(ctl_ready),
        .ctl_valid(ctl_valid), .ctl_char(ctl_char)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] wl;
        logic [7:0] s0, s1, g0, g1;
    } vec_t;

    // Stop chars D3/C4, go chars F1/E2, masked to 5/6/7/8 bits.
    localparam vec_t VECS [6] = '{
        '{2'b10, 2'b11, 8'hD3, 8'hD3, 8'hF1, 8'hF1},
        '{2'b01, 2'b11, 8'hC4, 8'hC4, 8'hE2, 8'hE2},
        '{2'b11, 2'b11, 8'hD3, 8'hC4, 8'hF1, 8'hE2},
        '{2'b11, 2'b00, 8'h13, 8'h04, 8'h11, 8'h02},
        '{2'b10, 2'b01, 8'h13, 8'h13, 8'h31, 8'h31},
        '{2'b01, 2'b10, 8'h44, 8'h44, 8'h62, 8'h62}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ctl_ready = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Inputs were set after a negedge; one edge later the first char shows.
    task automatic expect_burst(input string req, input logic [7:0] c0, input logic [7:0] c1);
        @(negedge clk);
        chk({req, " valid first"}, {7'd0, ctl_valid}, 8'd1);
        chk({req, " char first"}, ctl_char, c0);
        @(negedge clk);
        chk("R8 held valid", {7'd0, ctl_valid}, 8'd1);
        chk("R8 held char", ctl_char, c0);
        ctl_ready = 1'b1;
        @(negedge clk);
        chk({req, " valid second"}, {7'd0, ctl_valid}, 8'd1);
        chk({req, " char second"}, ctl_char, c1);
        @(negedge clk);
        chk("R8 drops after two", {7'd0, ctl_valid}, 8'd0);
        ctl_ready = 1'b0;
    endtask

    task automatic expect_quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, {7'd0, ctl_valid}, 8'd0);
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog run hung");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 in reset", {7'd0, ctl_valid}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {7'd0, ctl_valid}, 8'd0);

        // Table walk: R2 R3 R4 R9 for each mode / word length pairing
        for (int v = 0; v < 6; v++) begin
            do_reset();
            sw_fc_en = 1'b1; tx_mode = VECS[v].mode; word_len = VECS[v].wl;
            rx_level = 7'd10;
            expect_quiet("R2 below halt", 2);
            rx_level = 7'd40;
            expect_burst("R2 R3 R9 stop", VECS[v].s0, VECS[v].s1);
            rx_level = 7'd8;
            expect_burst("R4 R3 R9 go", VECS[v].g0, VECS[v].g1);
        end

        // R2 boundary, R5 no repeat, R4 boundary
        do_reset();
        sw_fc_en = 1'b1; tx_mode = 2'b10; word_len = 2'b11;
        rx_level = 7'd16;
        expect_quiet("R2 equal halt", 3);
        rx_level = 7'd17;
        expect_burst("R2 just above", 8'hD3, 8'hD3);
        expect_quiet("R5 no second stop", 4);
        rx_level = 7'd9;
        expect_quiet("R4 above resume", 3);
        rx_level = 7'd8;
        expect_burst("R4 equal resume", 8'hF1, 8'hF1);
        expect_quiet("R5 no go without stop", 3);

        // R6: mode none and disabled enable stay quiet
        do_reset();
        sw_fc_en = 1'b1; tx_mode = 2'b00; rx_level = 7'd60;
        expect_quiet("R6 mode none", 4);
        sw_fc_en = 1'b0; tx_mode = 2'b11;
        expect_quiet("R6 disabled", 4);

        // R7 + R10: auto go burst after disable, with captured mode
        sw_fc_en = 1'b1;
        expect_burst("R7 stop first", 8'hD3, 8'hC4);
        sw_fc_en = 1'b0; tx_mode = 2'b01;
        expect_burst("R7 R10 auto go", 8'hF1, 8'hE2);
        expect_quiet("R7 quiet after", 3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule